// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a serial byte memory as a slave on a two-wire bus. It holds two blocks of byte storage, 512 bytes with the default parameters, in a synchronous array. It watches the clock line and the data line as ordinary inputs sampled by a fast system clock. It pulls the data line low through an open-drain enable output. From the filtered lines it finds start and stop conditions, then reads a control byte, then a word address. It takes single-byte and page writes into a page buffer. When a stop arrives, it commits the buffered bytes to the array and then reports busy for a fixed number of system clocks.

For reads it keeps one address pointer. A current-address read returns the byte at the pointer. A random read first writes only a word address, then a repeated start ends that write and a read control byte follows. A sequential read goes on as long as the master acknowledges each byte. A write-protect input blocks every commit but leaves reads unaffected.

The bus state machine has these states: `ST_IDLE` (waiting for a start), `ST_CTRL` (shifting in the control byte), `ST_CTRL_ACK` (acknowledge slot for the control byte, driven only on a match while not busy), `ST_ADDR` (shifting in the word address), `ST_ADDR_ACK`, `ST_WDATA` (shifting in a data byte), `ST_WDATA_ACK`, `ST_RDATA` (shifting out a byte) and `ST_RACK` (sampling the master's acknowledge).

The transitions are:
- A start moves every state to `ST_CTRL`. A stop moves every state to `ST_IDLE`.
- In each shift state, the clock fall after the eighth bit moves to the matching acknowledge state.
- From `ST_CTRL_ACK`, the next fall moves to `ST_IDLE` (no acknowledge was given), `ST_RDATA` (read) or `ST_ADDR` (write).
- `ST_ADDR_ACK` and `ST_WDATA_ACK` move to `ST_WDATA`.
- `ST_RDATA` moves to `ST_RACK` after its eighth bit.
- `ST_RACK` moves back to `ST_RDATA` when the master acknowledges, and to `ST_IDLE` when it does not.

Top module: `twi_eeprom`

## Requirements
- R1: The control byte carries the device code 1010 in bits 7..4, ignores bits 3..2, carries the block select in bit 1 and the direction in bit 0 (1 = read). A control byte with a matching code is acknowledged while the device is idle. Any other code gets no acknowledge.
- R2: A write of one data byte followed by a stop stores that byte at the word address, and a later read of that address returns it.
- R3: In a page write, each data byte goes to the pointer, and then only the low PAGE_AW address bits advance, wrapping inside the current page.
- R4: Bytes are committed only by a stop that follows at least one data byte. A write that carries only a word address changes no stored byte and starts no busy period.
- R5: While the write-protect input is high at the stop, nothing is committed and no busy period starts. Reads work normally.
- R6: After a commit, the device leaves its control byte unacknowledged for BUSY_CYC system clocks after the last byte is stored.
- R7: A current-address read returns the byte at the pointer, and the pointer then moves to the next address.
- R8: While the master acknowledges, bytes stream out from consecutive addresses, and the last address wraps to address 0.
- R9: The block-select bit of an acknowledged control byte becomes the top bit of the pointer, so the same word address reaches different bytes in the two blocks.
- R10: After reset the data line is released. The slave changes its drive of the data line only while the clock line is low.
- R11: In a random read, the word address sent in the write phase sets the pointer, which survives the repeated start, and the first byte read comes from that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| wp_i | input | 1 | Write protect, high blocks every commit |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |

## Verification
The bench builds the slave with BLK_AW=5, PAGE_AW=3 and BUSY_CYC=300, which gives a 64-byte array with 8-byte pages. At this size the bench can fill the whole array with page writes and read it back in one sequential read that crosses the top address and wraps. It can also test page wrap, block select and the acknowledge during the busy window, all with expected bytes computed from an address formula. The busy length is larger than the time needed to send one control byte, so a control byte sent right after a write always lands inside the busy window.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
    import twi_eeprom_pkg::*;
#(
    parameter int BLK_AW      = 8,
    parameter int PAGE_AW     = 4,
    parameter int BUSY_CYC    = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    localparam int MEM_AW  = BLK_AW + 1;
    localparam int PAGES   = 2 ** PAGE_AW;
    localparam int PBASE_W = MEM_AW - PAGE_AW;
    localparam int BUSY_W  = $clog2(BUSY_CYC + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    bus_state_e          state_q;
    logic [3:0]          bitcnt_q;
    logic [7:0]          shreg_q, txreg_q;
    logic [MEM_AW-1:0]   ptr_q;
    logic                ack_q, rw_q, mnack_q;
    logic [7:0]          pbuf [PAGES];
    logic [PAGES-1:0]    pvalid_q, cvalid_q;
    logic                commit_act_q;
    logic [PAGE_AW-1:0]  cidx_q;
    logic [PBASE_W-1:0]  cbase_q;
    logic [BUSY_W-1:0]   busy_cnt_q;
    logic                busy;
    logic [7:0]          rd_q;
    logic                mem_we;

    assign busy   = commit_act_q || (busy_cnt_q != '0);
    assign mem_we = commit_act_q && cvalid_q[cidx_q];

    twi_mem_array #(.AW(MEM_AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr({cbase_q, cidx_q}), .wdata(pbuf[cidx_q]),
        .raddr(ptr_q), .rdata(rd_q)
    );

    // State register together with the bit and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            bitcnt_q     <= '0;
            shreg_q      <= '0;
            txreg_q      <= '0;
            ptr_q        <= '0;
            ack_q        <= 1'b0;
            rw_q         <= 1'b0;
            mnack_q      <= 1'b1;
            pvalid_q     <= '0;
            cvalid_q     <= '0;
            commit_act_q <= 1'b0;
            cidx_q       <= '0;
            cbase_q      <= '0;
            busy_cnt_q   <= '0;
        end else begin
            // commit engine: one buffered byte per cycle, then the busy window
            if (commit_act_q) begin
                cidx_q <= cidx_q + 1'b1;
                if (cidx_q == '1) begin
                    commit_act_q <= 1'b0;
                    busy_cnt_q   <= BUSY_W'(BUSY_CYC);
                end
            end else if (busy_cnt_q != '0) begin
                busy_cnt_q <= busy_cnt_q - 1'b1;
            end

            if (start_det) begin
                state_q  <= ST_CTRL;
                bitcnt_q <= '0;
                pvalid_q <= '0;
            end else if (stop_det) begin
                state_q  <= ST_IDLE;
                pvalid_q <= '0;
                if ((|pvalid_q) && !wp_i) begin
                    commit_act_q <= 1'b1;
                    cidx_q       <= '0;
                    cbase_q      <= ptr_q[MEM_AW-1:PAGE_AW];
                    cvalid_q     <= pvalid_q;
                end
            end else begin
                unique case (state_q)
                    ST_CTRL, ST_ADDR, ST_WDATA: begin
                        if (scl_rise && bitcnt_q < 4'd8) begin
                            shreg_q  <= {shreg_q[6:0], sda_s};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            bitcnt_q <= '0;
                            if (state_q == ST_CTRL) begin
                                ack_q   <= (shreg_q[7:4] == DEV_CODE) && !busy;
                                rw_q    <= shreg_q[0];
                                state_q <= ST_CTRL_ACK;
                                if ((shreg_q[7:4] == DEV_CODE) && !busy)
                                    ptr_q[MEM_AW-1] <= shreg_q[1];
                            end else if (state_q == ST_ADDR) begin
                                ptr_q[BLK_AW-1:0] <= shreg_q[BLK_AW-1:0];
                                pvalid_q          <= '0;
                                state_q           <= ST_ADDR_ACK;
                            end else begin
                                pbuf[ptr_q[PAGE_AW-1:0]]     <= shreg_q;
                                pvalid_q[ptr_q[PAGE_AW-1:0]] <= 1'b1;
                                ptr_q[PAGE_AW-1:0]           <= ptr_q[PAGE_AW-1:0] + 1'b1;
                                state_q                      <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_CTRL_ACK: if (scl_fall) begin
                        if (!ack_q) state_q <= ST_IDLE;
                        else if (rw_q) begin
                            state_q  <= ST_RDATA;
                            txreg_q  <= rd_q;
                            bitcnt_q <= '0;
                        end else state_q <= ST_ADDR;
                    end
                    ST_ADDR_ACK, ST_WDATA_ACK: if (scl_fall) state_q <= ST_WDATA;
                    ST_RDATA: if (scl_fall) begin
                        if (bitcnt_q == 4'd7) begin
                            state_q  <= ST_RACK;
                            ptr_q    <= ptr_q + 1'b1;
                            bitcnt_q <= '0;
                        end else begin
                            txreg_q  <= {txreg_q[6:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mnack_q <= sda_s;
                        if (scl_fall) begin
                            if (mnack_q) state_q <= ST_IDLE;
                            else begin
                                state_q <= ST_RDATA;
                                txreg_q <= rd_q;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_CTRL_ACK:               sda_oe_o = ack_q;
            ST_ADDR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_RDATA:                  sda_oe_o = ~txreg_q[7];
            default:                   sda_oe_o = 1'b0;
        endcase
    end

    // R10: drive changes only follow a low clock line
    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_s));

    // R5: a commit never begins while write protect was high
    p_no_commit_wp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit_act_q) |-> !$past(wp_i));

    // R6: control byte decided during busy is never acknowledged
    p_busy_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state_q == ST_CTRL_ACK) && $past(busy)) |-> !sda_oe_o);

    // R3: the page part of the pointer holds across a data byte
    p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA_ACK && $past(state_q) == ST_WDATA)
        |-> ptr_q[MEM_AW-1:PAGE_AW] == $past(ptr_q[MEM_AW-1:PAGE_AW]));

    // R4: the array is written only by the commit engine after a stop
    p_write_only_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (commit_act_q && state_q != ST_WDATA_ACK));

endmodule

// File: tb/twi_eeprom_test.sv
module twi_eeprom_test;
    localparam int Q     = 4;
    localparam int BUSY  = 300;
    localparam int MSIZE = 64;
    localparam int PG    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
    logic oe;
    logic sda_bus;
    assign sda_bus = m_sda & ~oe;

    always #2.5 clk = ~clk;

    twi_eeprom #(.BLK_AW(5), .PAGE_AW(3), .BUSY_CYC(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .wp_i(wp), .sda_oe_o(oe)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] model [MSIZE];
    logic [7:0] rbuf [80];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(2 * Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); b = sda_bus;
        tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic wbyte(logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        acked = !a;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(!mack);
    endtask

    function automatic logic [7:0] ctrl(logic blk, logic rd);
        return {4'b1010, 2'b00, blk, rd};
    endfunction

    function automatic logic [7:0] pat(int a, int s);
        return 8'((a * 37 + s) & 255);
    endfunction

    task automatic wait_ready();
        tick(BUSY + PG + 20);
    endtask

    // page write of n bytes starting at a (6-bit address), updates the model
    task automatic pwrite(string req, int a, int n, int seed, logic upd);
        logic ak;
        bstart();
        wbyte(ctrl(a[5], 1'b0), ak); chk(req, ak, 1);
        wbyte(8'(a & 31), ak);
        for (int i = 0; i < n; i++) begin
            int ad = (a & ~(PG - 1)) | ((a + i) & (PG - 1));
            wbyte(pat(ad, seed), ak);
            if (upd) model[ad] = pat(ad, seed);
        end
        bstop();
    endtask

    task automatic rread(string req, int a, int n);
        logic ak;
        bstart();
        wbyte(ctrl(a[5], 1'b0), ak); chk(req, ak, 1);
        wbyte(8'(a & 31), ak);
        bstart();
        wbyte(ctrl(a[5], 1'b1), ak); chk(req, ak, 1);
        for (int i = 0; i < n; i++) rbyte(rbuf[i], i != n - 1);
        bstop();
    endtask

    task automatic cread(logic blk, output logic [7:0] d);
        logic ak;
        bstart();
        wbyte(ctrl(blk, 1'b1), ak); chk("R7 ctrl ack", ak, 1);
        rbyte(d, 1'b0);
        bstop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] d;
        tick(4);
        chk("R10 reset release", oe, 0);
        rst_n = 1'b1;
        tick(4);
        chk("R10 idle release", oe, 0);

        // R1: foreign device codes are ignored
        bstart(); wbyte(8'hB0, ak); chk("R1 wrong code nack", ak, 0); bstop();
        bstart(); wbyte(8'h20, ak); chk("R1 wrong code nack", ak, 0); bstop();

        // fill the array with page writes, polling busy after each (R6)
        for (int p = 0; p < MSIZE / PG; p++) begin
            pwrite("R1 ctrl ack", p * PG, PG, 11, 1'b1);
            bstart(); wbyte(ctrl(1'b0, 1'b0), ak); chk("R6 busy nack", ak, 0); bstop();
            wait_ready();
        end

        // R11/R8: random read from 0 streams through the top and wraps
        rread("R11 ctrl ack", 0, MSIZE + 3);
        chk("R11 first byte", rbuf[0], model[0]);
        for (int i = 1; i < MSIZE + 3; i++) chk("R8 sequential", rbuf[i], model[i % MSIZE]);

        // R7: pointer now at 3
        cread(1'b0, d); chk("R7 current read", d, model[3]);
        cread(1'b0, d); chk("R7 pointer advance", d, model[4]);
        // R9: block bit selects the upper half
        cread(1'b1, d); chk("R9 block select current", d, model[37]);

        // R3: page wrap, 5 bytes from 13 land on 13,14,15,8,9
        pwrite("R3 ctrl ack", 13, 5, 99, 1'b1);
        wait_ready();
        rread("R3 ctrl ack", 8, PG);
        for (int i = 0; i < PG; i++) chk("R3 page wrap", rbuf[i], model[8 + i]);

        // R2: single byte write and read back
        pwrite("R2 ctrl ack", 22, 1, 201, 1'b1);
        wait_ready();
        rread("R2 ctrl ack", 22, 2);
        chk("R2 byte write", rbuf[0], model[22]);
        chk("R2 neighbour kept", rbuf[1], model[23]);

        // R4: address-only write stores nothing and starts no busy window
        bstart(); wbyte(ctrl(1'b0, 1'b0), ak); wbyte(8'd20, ak); bstop();
        bstart(); wbyte(ctrl(1'b0, 1'b0), ak); chk("R4 no busy", ak, 1); bstop();
        rread("R4 ctrl ack", 20, 1);
        chk("R4 unchanged", rbuf[0], model[20]);

        // R5: write protect blocks the commit and the busy window
        wp = 1'b1;
        pwrite("R5 ctrl ack", 40, 3, 77, 1'b0);
        bstart(); wbyte(ctrl(1'b1, 1'b0), ak); chk("R5 no busy", ak, 1); bstop();
        rread("R5 read ok", 40, 3);
        for (int i = 0; i < 3; i++) chk("R5 unchanged", rbuf[i], model[40 + i]);
        wp = 1'b0;

        // R9: same word address, two blocks
        pwrite("R9 ctrl ack", 34, 1, 55, 1'b1);
        wait_ready();
        rread("R9 ctrl ack", 34, 1);
        chk("R9 upper block", rbuf[0], model[34]);
        rread("R9 ctrl ack", 2, 1);
        chk("R9 lower block", rbuf[0], model[2]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule